// File: doc/BRIEF.md
# Configurable Spiking Component Update Unit

This unit keeps a bank of identical component records in one single-port state memory and updates them one at a time through a single shared datapath. Each record holds an 8-bit state and a 2-bit mode. The mode decides how the state bits are read. A record can be a leaky integrate-and-fire neuron, a plastic synapse that learns from spike timing, or an axon whose delay is trained from spike timing. A fourth mode leaves the record untouched.

Two kinds of pass share the memory. A `tick` pulse starts a sweep over every record in address order, which applies leak, integration, refractory counting and ramp steps. A spike event names one record and carries a flag for pre- or post-synaptic. It starts a two-cycle read-modify-write on that record only. Neurons that cross threshold and axon ramps that reach their delay emit a one-cycle spike on the output, carrying the record's address.

A configuration port reads and writes whole records while the unit is idle. It is used to load modes and states before operation and to inspect them afterwards.

Top module: `spk_unit`

## Requirements
- R1: After reset, `spk_valid` and `cfg_rvalid` are 0. No spike appears until a pass runs.
- R2: A record is laid out as {mode[11:10], aux[9:8], state[7:0]}. Mode 0 is neuron, 1 is plastic synapse, 2 is delay axon and 3 is inert. While idle, `cfg_we` writes `cfg_wdata` to `cfg_addr`. `cfg_re` returns the stored record on `cfg_rdata`, with `cfg_rvalid` high, one cycle later.
- R3: While idle, a configuration access has priority over `tick`, and `tick` has priority over an event. A request that loses, or that arrives while a pass runs, is dropped. A sweep takes 2 cycles per record in address order. A spike from record A appears 2A+2 cycles after the edge that takes the tick.
- R4: The leak of a field f by shift k subtracts max(f>>k, 1) from f, and 0 stays 0.
- R5: In neuron mode (membrane in state[7:4], current in state[3:0]), with aux 0, a tick sets the membrane to leak(membrane, 2) plus the current, saturating at 15. It sets the current to leak(current, 2).
- R6: If the new membrane from R5 is at least 12, the neuron emits its address on the spike output. The membrane becomes 0 and aux becomes the refractory count 2.
- R7: In neuron mode with aux nonzero, a tick decrements aux, holds the membrane at 0 and still leaks the current. Spike events have no effect on the record.
- R8: In neuron mode with aux 0, a pre-synaptic event adds 4 to the current, saturating at 15. A post-synaptic event has no effect.
- R9: In synapse mode (polarity state[7], window state[6:4], pre flag state[3], weight state[2:0]), an event is handled as follows when the window is 0 or the event's polarity equals state[7]. The event writes its polarity (0 for pre, 1 for post) to state[7] and sets the window to 7. A pre event sets state[3]. A tick clears state[3] and applies leak with shift 1 to the window.
- R10: In synapse mode, an event of the opposite polarity that arrives while the window is nonzero changes the weight. The weight goes up by 1 if the polarity bit is 0 and down by 1 if it is 1, saturating at 7 and 0. The window is then cleared, and a pre event still sets state[3].
- R11: In delay mode (ramp state[7:4], delay state[3:0], active flag aux[0]), a pre event sets the ramp to 0 and the active flag to 1. On a tick, an active ramp below 15 increments and emits a spike when the new ramp equals the delay. An active ramp at 15 clears the active flag.
- R12: In delay mode, a post event moves the delay one step toward the current ramp. It leaves the delay unchanged when the two are equal.
- R13: Mode 3 records are never changed by a pass, and no pass ever alters the mode field of any record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-step pulse that starts a sweep |
| ev_valid | input | 1 | Spike event strobe |
| ev_addr | input | ADDR_W | Record addressed by the event |
| ev_post | input | 1 | Event polarity: 0 pre-synaptic, 1 post-synaptic |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration record address |
| cfg_wdata | input | WORD_W | Record written by the configuration port |
| cfg_rdata | output | WORD_W | Record returned by a configuration read |
| cfg_rvalid | output | 1 | High in the cycle after an accepted read |
| spk_valid | output | 1 | One-cycle output spike strobe |
| spk_addr | output | ADDR_W | Address of the spiking record |

## Verification
A wrong field update never shows directly at the ports. It stays inside the record until a configuration read brings it out, or until it shifts the tick on which a neuron fires or a ramp meets its delay. The bench therefore reads each record back right after one tick or one event, so a fault appears within a single pass. Faults in the sweep order or in the read-modify-write pairing show up as a spike cycle other than 2A+2 after the tick, or as a record that changes when it should not. Dropped or wrongly prioritised requests show up as a record that took an update it should not have.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;

  typedef enum logic [1:0] {
    MODE_LIF  = 2'd0,
    MODE_STDP = 2'd1,
    MODE_DLY  = 2'd2,
    MODE_OFF  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SW_RD = 3'd1,
    ST_SW_WR = 3'd2,
    ST_EV_RD = 3'd3,
    ST_EV_WR = 3'd4
  } phase_e;

  // subtract the shifted field, at least one, floor at zero
  function automatic logic [3:0] leak4(input logic [3:0] f, input int sh);
    logic [3:0] d;
    d = f >> sh;
    if (d == 4'd0) d = 4'd1;
    return (f == 4'd0) ? 4'd0 : f - d;
  endfunction

endpackage

// File: rtl/spk_mem.sv
`timescale 1ns/1ps
module spk_mem #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    q <= ram[addr];
  end

endmodule

// File: rtl/spk_ctrl.sv
`timescale 1ns/1ps
module spk_ctrl
  import spk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_post,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              sel_cfg,
  output logic              upd_tick,
  output logic              upd_post,
  output logic              wr_phase,
  output logic              busy,
  output logic              cfg_rvalid
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  phase_e            st;
  logic [ADDR_W-1:0] idx;
  logic              post_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      idx        <= '0;
      post_q     <= 1'b0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= (st == ST_IDLE) && cfg_re;
      case (st)
        ST_IDLE: begin
          if (cfg_we || cfg_re) begin
            st <= ST_IDLE;
          end else if (tick) begin
            st  <= ST_SW_RD;
            idx <= '0;
          end else if (ev_valid) begin
            st     <= ST_EV_RD;
            idx    <= ev_addr;
            post_q <= ev_post;
          end
        end
        ST_SW_RD: st <= ST_SW_WR;
        ST_SW_WR: begin
          if (idx == LAST) begin
            st <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_SW_RD;
          end
        end
        ST_EV_RD: st <= ST_EV_WR;
        ST_EV_WR: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_cfg  = (st == ST_IDLE);
    busy     = (st != ST_IDLE);
    upd_tick = (st == ST_SW_WR);
    upd_post = post_q;
    wr_phase = (st == ST_SW_WR) || (st == ST_EV_WR);
    if (st == ST_IDLE) begin
      mem_addr = cfg_addr;
      mem_we   = cfg_we;
    end else begin
      mem_addr = idx;
      mem_we   = wr_phase;
    end
  end

endmodule

// File: rtl/spk_update.sv
`timescale 1ns/1ps
module spk_update
  import spk_pkg::*;
#(
  parameter int AUXW      = 2,
  parameter int THRESH    = 12,
  parameter int REFR      = 2,
  parameter int SHIFT_CUR = 2,
  parameter int SHIFT_MEM = 2,
  parameter int SHIFT_WIN = 1,
  parameter int PSC_STEP  = 4,
  localparam int WW       = AUXW + 10
) (
  input  logic [WW-1:0] cur,
  input  logic          is_tick,
  input  logic          post,
  output logic [WW-1:0] nxt,
  output logic          fire
);

  localparam logic [4:0]      THR5  = 5'(THRESH);
  localparam logic [4:0]      STEP5 = 5'(PSC_STEP);
  localparam logic [AUXW-1:0] ONE_A = AUXW'(1);

  mode_e           mode;
  logic [AUXW-1:0] aux, n_aux;
  logic [7:0]      s, n_s;
  logic [3:0]      hi, lo, vn, wl;
  logic [4:0]      sum, ps;

  always_comb begin
    mode  = mode_e'(cur[WW-1 -: 2]);
    aux   = cur[8 +: AUXW];
    s     = cur[7:0];
    hi    = s[7:4];
    lo    = s[3:0];
    n_s   = s;
    n_aux = aux;
    fire  = 1'b0;
    sum   = '0;
    ps    = '0;
    vn    = '0;
    wl    = '0;
    case (mode)
      MODE_LIF: begin
        if (is_tick) begin
          sum      = {1'b0, leak4(hi, SHIFT_MEM)} + {1'b0, lo};
          vn       = sum[4] ? 4'hF : sum[3:0];
          n_s[3:0] = leak4(lo, SHIFT_CUR);
          if (aux != '0) begin
            n_s[7:4] = 4'd0;
            n_aux    = aux - ONE_A;
          end else if ({1'b0, vn} >= THR5) begin
            fire     = 1'b1;
            n_s[7:4] = 4'd0;
            n_aux    = AUXW'(REFR);
          end else begin
            n_s[7:4] = vn;
          end
        end else if (aux == '0 && !post) begin
          ps       = {1'b0, lo} + STEP5;
          n_s[3:0] = ps[4] ? 4'hF : ps[3:0];
        end
      end
      MODE_STDP: begin
        if (is_tick) begin
          wl       = leak4({1'b0, s[6:4]}, SHIFT_WIN);
          n_s[6:4] = wl[2:0];
          n_s[3]   = 1'b0;
        end else begin
          if (s[6:4] != 3'd0 && post != s[7]) begin
            if (!s[7]) n_s[2:0] = (s[2:0] == 3'd7) ? 3'd7 : s[2:0] + 3'd1;
            else       n_s[2:0] = (s[2:0] == 3'd0) ? 3'd0 : s[2:0] - 3'd1;
            n_s[6:4] = 3'd0;
          end else begin
            n_s[7]   = post;
            n_s[6:4] = 3'd7;
          end
          if (!post) n_s[3] = 1'b1;
        end
      end
      MODE_DLY: begin
        if (is_tick) begin
          if (aux[0]) begin
            if (hi == 4'hF) begin
              n_aux[0] = 1'b0;
            end else begin
              n_s[7:4] = hi + 4'd1;
              fire     = ((hi + 4'd1) == lo);
            end
          end
        end else if (!post) begin
          n_s[7:4] = 4'd0;
          n_aux[0] = 1'b1;
        end else if (lo < hi) begin
          n_s[3:0] = lo + 4'd1;
        end else if (lo > hi) begin
          n_s[3:0] = lo - 4'd1;
        end
      end
      default: ;
    endcase
    nxt = {cur[WW-1 -: 2], n_aux, n_s};
  end

endmodule

// File: rtl/spk_unit.sv
`timescale 1ns/1ps
module spk_unit #(
  parameter int ADDR_W     = 4,
  parameter int REFR_TICKS = 2,
  parameter int THRESH     = 12,
  parameter int SHIFT_CUR  = 2,
  parameter int SHIFT_MEM  = 2,
  parameter int SHIFT_WIN  = 1,
  parameter int PSC_STEP   = 4,
  localparam int AUXW      = (REFR_TICKS < 2) ? 1 : $clog2(REFR_TICKS + 1),
  localparam int WORD_W    = AUXW + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_post,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  output logic              spk_valid,
  output logic [ADDR_W-1:0] spk_addr
);

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wdata, mem_q, upd_word;
  logic              sel_cfg, upd_tick, upd_post, wr_phase, busy, fire;

  spk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .ev_post(ev_post), .cfg_we(cfg_we),
    .cfg_re(cfg_re), .cfg_addr(cfg_addr), .mem_addr(mem_addr),
    .mem_we(mem_we), .sel_cfg(sel_cfg), .upd_tick(upd_tick),
    .upd_post(upd_post), .wr_phase(wr_phase), .busy(busy),
    .cfg_rvalid(cfg_rvalid)
  );

  spk_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .q(mem_q)
  );

  spk_update #(
    .AUXW(AUXW), .THRESH(THRESH), .REFR(REFR_TICKS),
    .SHIFT_CUR(SHIFT_CUR), .SHIFT_MEM(SHIFT_MEM), .SHIFT_WIN(SHIFT_WIN),
    .PSC_STEP(PSC_STEP)
  ) u_upd (
    .cur(mem_q), .is_tick(upd_tick), .post(upd_post),
    .nxt(upd_word), .fire(fire)
  );

  assign mem_wdata = sel_cfg ? cfg_wdata : upd_word;
  assign cfg_rdata = mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spk_valid <= 1'b0;
      spk_addr  <= '0;
    end else begin
      spk_valid <= wr_phase && fire;
      spk_addr  <= mem_addr;
    end
  end

endmodule

// File: rtl/spk_unit_chk.sv
`timescale 1ns/1ps
module spk_unit_chk #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_q,
  input logic              busy,
  input logic              cfg_re,
  input logic              cfg_rvalid,
  input logic              spk_valid,
  input logic [ADDR_W-1:0] spk_addr
);

  assert_spike_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    spk_valid |-> $past(mem_we && busy));

  assert_spike_addr_R3: assert property (@(posedge clk) disable iff (rst)
    spk_valid |-> (spk_addr == $past(mem_addr)));

  assert_rmw_pairing_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy) |-> ((mem_addr == $past(mem_addr)) && !$past(mem_we)));

  assert_rvalid_source_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> $past(cfg_re && !busy));

  assert_inert_kept_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy && mem_q[WORD_W-1 -: 2] == 2'd3) |-> (mem_wdata == mem_q));

  assert_mode_kept_R13: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy) |-> (mem_wdata[WORD_W-1 -: 2] == mem_q[WORD_W-1 -: 2]));

endmodule

bind spk_unit spk_unit_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_q(mem_q), .busy(busy), .cfg_re(cfg_re),
  .cfg_rvalid(cfg_rvalid), .spk_valid(spk_valid), .spk_addr(spk_addr)
);

// File: tb/spk_unit_test.sv
`timescale 1ns/1ps
module spk_unit_test;

  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int WW = 12;
  localparam logic [WW-1:0] INERT = 12'hC00;

  // {req[30:27], init[26:15], op[14:13], expect[12:1], spike[0]}; op 0 tick, 1 pre, 2 post
  localparam int NV = 30;
  localparam logic [30:0] VEC [NV] = '{
    {4'd5,  12'h008, 2'd0, 12'h086, 1'b0},  // R5
    {4'd5,  12'h066, 2'd0, 12'h0B5, 1'b0},  // R5
    {4'd6,  12'h086, 2'd0, 12'h205, 1'b1},  // R6
    {4'd6,  12'h00F, 2'd0, 12'h20C, 1'b1},  // R6
    {4'd8,  12'h00E, 2'd1, 12'h00F, 1'b0},  // R8 saturation
    {4'd8,  12'h032, 2'd1, 12'h036, 1'b0},  // R8
    {4'd8,  12'h032, 2'd2, 12'h032, 1'b0},  // R8 post ignored
    {4'd7,  12'h205, 2'd0, 12'h104, 1'b0},  // R7
    {4'd7,  12'h104, 2'd1, 12'h104, 1'b0},  // R7 event ignored
    {4'd7,  12'h104, 2'd0, 12'h003, 1'b0},  // R7 last refractory tick
    {4'd4,  12'h010, 2'd0, 12'h000, 1'b0},  // R4 floor at zero
    {4'd9,  12'h405, 2'd1, 12'h47D, 1'b0},  // R9 pre opens
    {4'd9,  12'h47D, 2'd0, 12'h445, 1'b0},  // R9 tick leak
    {4'd10, 12'h445, 2'd2, 12'h406, 1'b0},  // R10 increment
    {4'd10, 12'h427, 2'd2, 12'h407, 1'b0},  // R10 hold at 7
    {4'd9,  12'h403, 2'd2, 12'h4F3, 1'b0},  // R9 post opens
    {4'd10, 12'h490, 2'd1, 12'h488, 1'b0},  // R10 hold at 0
    {4'd9,  12'h4A3, 2'd2, 12'h4F3, 1'b0},  // R9 same polarity restarts
    {4'd4,  12'h493, 2'd0, 12'h483, 1'b0},  // R4 window 1 to 0
    {4'd11, 12'h893, 2'd1, 12'h903, 1'b0},  // R11 start
    {4'd11, 12'h923, 2'd0, 12'h933, 1'b1},  // R11 match
    {4'd11, 12'h933, 2'd0, 12'h943, 1'b0},  // R11 past match
    {4'd11, 12'h843, 2'd0, 12'h843, 1'b0},  // R11 inactive
    {4'd11, 12'h9F2, 2'd0, 12'h8F2, 1'b0},  // R11 stop at 15
    {4'd11, 12'h9EF, 2'd0, 12'h9FF, 1'b1},  // R11 match at 15
    {4'd12, 12'h952, 2'd2, 12'h953, 1'b0},  // R12 up
    {4'd12, 12'h859, 2'd2, 12'h858, 1'b0},  // R12 down
    {4'd12, 12'h855, 2'd2, 12'h855, 1'b0},  // R12 equal
    {4'd13, 12'hC5A, 2'd0, 12'hC5A, 1'b0},  // R13 tick
    {4'd13, 12'hF5A, 2'd1, 12'hF5A, 1'b0}   // R13 event
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0, ev_valid = 1'b0, ev_post = 1'b0;
  logic [AW-1:0] ev_addr = '0, cfg_addr = '0;
  logic          cfg_we = 1'b0, cfg_re = 1'b0;
  logic [WW-1:0] cfg_wdata = '0;
  logic [WW-1:0] cfg_rdata;
  logic          cfg_rvalid, spk_valid;
  logic [AW-1:0] spk_addr;

  int total = 0, bad = 0, spk_n = 0;
  logic [AW-1:0] spk_last = '0;
  bit done = 1'b0;

  spk_unit uut (
    .clk(clk), .rst(rst), .tick(tick), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_post(ev_post), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .spk_valid(spk_valid), .spk_addr(spk_addr)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (!rst && spk_valid) begin
    spk_n    <= spk_n + 1;
    spk_last <= spk_addr;
  end

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [WW-1:0] d, output logic v);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0; d = cfg_rdata; v = cfg_rvalid;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2 * N + 2) @(negedge clk);
  endtask

  task automatic send_ev(input logic [AW-1:0] a, input logic post);
    @(negedge clk); ev_valid = 1'b1; ev_addr = a; ev_post = post;
    @(negedge clk); ev_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] d;
    logic v;
    int base, cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(1, "spk_valid after reset", 32'(spk_valid), 32'd0);
    chk(1, "cfg_rvalid after reset", 32'(cfg_rvalid), 32'd0);
    for (int a = 0; a < N; a++) wr(AW'(a), INERT);
    repeat (5) @(negedge clk);
    chk(1, "no spike while idle", 32'(spk_n), 32'd0);

    // R2 configuration write and read
    wr(4'd3, 12'h9A5);
    wr(4'd12, 12'h1C3);
    rd(4'd3, d, v);
    chk(2, "read addr 3", 32'(d), 32'h9A5);
    chk(2, "rvalid", 32'(v), 32'd1);
    rd(4'd12, d, v);
    chk(2, "read addr 12", 32'(d), 32'h1C3);
    @(negedge clk);
    chk(2, "rvalid drops", 32'(cfg_rvalid), 32'd0);
    wr(4'd3, INERT);
    wr(4'd12, INERT);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [30:0]   vv;
      vv = VEC[i];
      a  = AW'(i % N);
      wr(a, vv[26:15]);
      base = spk_n;
      case (vv[14:13])
        2'd0:    pulse_tick();
        2'd1:    send_ev(a, 1'b0);
        default: send_ev(a, 1'b1);
      endcase
      rd(a, d, v);
      chk(int'(vv[30:27]), $sformatf("vector %0d record", i), 32'(d), 32'(vv[12:1]));
      chk(int'(vv[30:27]), $sformatf("vector %0d spike count", i), 32'(spk_n - base), 32'(vv[0]));
      if (vv[0]) chk(int'(vv[30:27]), $sformatf("vector %0d spike addr", i), 32'(spk_last), 32'(a));
      wr(a, INERT);
    end

    // R3 spike timing within the sweep: record 7 fires at 2*7+2 cycles
    wr(4'd7, 12'h086);
    @(negedge clk); tick = 1'b1;
    cnt = 0;
    while (cnt < 40) begin
      @(negedge clk); tick = 1'b0; cnt++;
      if (spk_valid) break;
    end
    chk(3, "spike cycle for record 7", 32'(cnt), 32'd17);
    chk(3, "spike address", 32'(spk_addr), 32'd7);
    repeat (2 * N) @(negedge clk);
    wr(4'd7, INERT);

    // R3 event during a sweep is dropped
    wr(4'd5, 12'h032);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; ev_valid = 1'b1; ev_addr = 4'd5; ev_post = 1'b0;
    @(negedge clk); ev_valid = 1'b0;
    repeat (2 * N + 2) @(negedge clk);
    rd(4'd5, d, v);
    chk(3, "event during sweep dropped", 32'(d), 32'h041);

    // R3 tick wins over a simultaneous event
    wr(4'd5, 12'h032);
    @(negedge clk); tick = 1'b1; ev_valid = 1'b1; ev_addr = 4'd5; ev_post = 1'b0;
    @(negedge clk); tick = 1'b0; ev_valid = 1'b0;
    repeat (2 * N + 2) @(negedge clk);
    rd(4'd5, d, v);
    chk(3, "tick over event", 32'(d), 32'h041);

    // R3 configuration write wins over a simultaneous tick
    base = spk_n;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'd5; cfg_wdata = 12'h086; tick = 1'b1;
    @(negedge clk); cfg_we = 1'b0; tick = 1'b0;
    repeat (2 * N + 2) @(negedge clk);
    rd(4'd5, d, v);
    chk(3, "write over tick record", 32'(d), 32'h086);
    chk(3, "write over tick no spike", 32'(spk_n - base), 32'd0);
    wr(4'd5, INERT);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule